// File: doc/BRIEF.md
# Two-Segment Thermal Code Converter

This block turns raw 12-bit thermal sensor readings into signed whole degrees Celsius. It can also turn a Celsius target back into the 12-bit code that a threshold comparator would be loaded with. Both directions use a linear model with two segments. The cold half of the code range shares one coefficient pair across all channels. The hot half has one pair for channel 0 and a second pair shared by every other channel.

The forward path is a single registered stage. The result is a right shift by 20 of `base − code·mul`, taken in 40-bit signed arithmetic. The same stage also gives the value in microkelvin. The reverse path forms `base − (temp·2^20)` and hands it to a restoring shift-subtract divider. The quotient is truncated toward zero and clamped to 0..0xFFF. Each path has its own request handshake, and the two paths run independently of each other.

Top module: `tsense_conv`

## Requirements
- R1: A forward request is taken whenever `fwd_valid` is high, and `fwd_ready` is always high. One cycle later `fwd_done` pulses and `fwd_temp` = floor((233832448 − code·124885) / 2^20) when code ≥ 0x500. `fwd_temp` changes only together with `fwd_done`.
- R2: For code < 0x500 on channel 0, `fwd_temp` = floor((271581184 − code·152253) / 2^20).
- R3: For code < 0x500 on any channel other than 0, `fwd_temp` = floor((289406976 − code·166723) / 2^20).
- R4: `fwd_ukelvin` = `fwd_temp`·1000000 + 273150000. It is updated in the same cycle as `fwd_temp`.
- R5: For a reverse target ≤ 70 °C, `rev_code` = trunc((233832448 − temp·2^20) / 124885), whatever the channel.
- R6: For a reverse target > 70 °C, `rev_code` = trunc((base − temp·2^20) / mul). Channel 0 uses base 271581184 and mul 152253. Every other channel uses base 289406976 and mul 166723.
- R7: When the reverse numerator is ≤ 0, `rev_code` is 0. When the quotient exceeds 4095, `rev_code` is 0xFFF.
- R8: A reverse request is taken only while `rev_ready` is high. `rev_ready` then stays low until `rev_done` pulses for one cycle, exactly 40 cycles after the request is taken. A request made while `rev_ready` is low is ignored and does not change the pending result. `rev_code` changes only together with `rev_done`.
- R9: A forward request taken in the same cycle as a reverse request, or while the divider is busy, completes with the R1 timing. It does not disturb the reverse result.
- R10: While `rst` is high and after it is released: `fwd_done` = 0, `rev_done` = 0, `rev_ready` = 1, `fwd_ready` = 1, and `fwd_temp`, `fwd_ukelvin` and `rev_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_valid | input | 1 | Forward request |
| fwd_ready | output | 1 | Forward path can take a request (always 1) |
| fwd_chan | input | CH_W | Channel of the forward request |
| fwd_code | input | 12 | Sensor code to convert |
| fwd_done | output | 1 | Forward result valid pulse |
| fwd_temp | output | OUT_W | Signed result in °C |
| fwd_ukelvin | output | UK_W | Result in microkelvin |
| rev_valid | input | 1 | Reverse request |
| rev_ready | output | 1 | Divider idle, request can be taken |
| rev_chan | input | CH_W | Channel of the reverse request |
| rev_temp | input | TEMP_W | Signed target in °C |
| rev_done | output | 1 | Reverse result valid pulse |
| rev_code | output | 12 | Clamped threshold code |

## Verification
Two events can land in the same cycle: a forward request being taken and a reverse request being taken. A forward request can also complete while the divider is partway through its iterations. The bench raises both valids on the same edge. It also injects a forward request in the middle of a division, together with a reverse request that is made while `rev_ready` is low. A run passes only if the forward result arrives one cycle after its request, the reverse result arrives exactly 40 cycles after its accepted request, and both values match the bench's own arithmetic for the original operands.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int CODE_W   = 12;
    localparam int SCALE_SH = 20;
    localparam int ACC_W    = 40;
    localparam int MUL_W    = 18;

    localparam logic [CODE_W-1:0] LOW_SEG_CODE = 12'h500;
    localparam int LOW_SEG_MAX_TEMP = 70;
    localparam longint UK_PER_C  = 1000000;
    localparam longint UK_OFFSET = 273150000;

    typedef enum logic [1:0] {
        SEG_LOW      = 2'd0,
        SEG_HI_FIRST = 2'd1,
        SEG_HI_OTHER = 2'd2
    } seg_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] base;
        logic [MUL_W-1:0]        mul;
    } seg_coef_t;

    function automatic seg_t pick_seg(input logic low, input logic first_chan);
        if (low)             return SEG_LOW;
        else if (first_chan) return SEG_HI_FIRST;
        else                 return SEG_HI_OTHER;
    endfunction

    function automatic seg_coef_t coef_of(input seg_t s);
        seg_coef_t c;
        case (s)
            SEG_HI_FIRST: begin c.base = 40'sd271581184; c.mul = 18'd152253; end
            SEG_HI_OTHER: begin c.base = 40'sd289406976; c.mul = 18'd166723; end
            default:      begin c.base = 40'sd233832448; c.mul = 18'd124885; end
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tsc_fwd.sv
module tsc_fwd
    import tsc_pkg::*;
#(
    parameter int CH_W  = 1,
    parameter int OUT_W = 16,
    parameter int UK_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic [CH_W-1:0]         chan,
    input  logic [CODE_W-1:0]       code,
    output logic                    done,
    output logic signed [OUT_W-1:0] temp,
    output logic [UK_W-1:0]         ukelvin
);
    seg_coef_t               cf;
    logic signed [ACC_W-1:0] code_s, mul_s, diff, scaled, uk_full;

    always_comb begin
        cf      = coef_of(pick_seg(code >= LOW_SEG_CODE, chan == '0));
        code_s  = $signed({{(ACC_W-CODE_W){1'b0}}, code});
        mul_s   = $signed({{(ACC_W-MUL_W){1'b0}}, cf.mul});
        diff    = cf.base - code_s * mul_s;
        scaled  = diff >>> SCALE_SH;
        uk_full = scaled * ACC_W'(UK_PER_C) + ACC_W'(UK_OFFSET);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            temp    <= '0;
            ukelvin <= '0;
        end else begin
            done <= take;
            if (take) begin
                temp    <= OUT_W'(scaled);
                ukelvin <= UK_W'(uk_full);
            end
        end
    end
endmodule

// File: rtl/tsc_div.sv
module tsc_div #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 18,
    parameter int Q_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] dvd;
    logic [DEN_W-1:0] rem, den_q, rem_nx;
    logic [DEN_W:0]   trial;
    logic             ge;
    logic [NUM_W-1:0] q_last;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        trial  = {rem, dvd[NUM_W-1]};
        ge     = trial >= {1'b0, den_q};
        rem_nx = ge ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
        q_last = {dvd[NUM_W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            dvd   <= '0;
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            quo   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                dvd   <= num;
                rem   <= '0;
                den_q <= den;
                cnt   <= '0;
            end else if (busy) begin
                dvd <= q_last;
                rem <= rem_nx;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(NUM_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quo  <= (|q_last[NUM_W-1:Q_W]) ? {Q_W{1'b1}} : q_last[Q_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/tsc_rev.sv
module tsc_rev
    import tsc_pkg::*;
#(
    parameter int CH_W   = 1,
    parameter int TEMP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic [CH_W-1:0]          chan,
    input  logic signed [TEMP_W-1:0] temp,
    output logic                     ready,
    output logic                     done,
    output logic [CODE_W-1:0]        code
);
    seg_coef_t               cf;
    logic signed [ACC_W-1:0] t_ext, num_s;
    logic [ACC_W-1:0]        num_u;
    logic                    busy;

    always_comb begin
        t_ext = $signed({{(ACC_W-TEMP_W){temp[TEMP_W-1]}}, temp});
        cf    = coef_of(pick_seg(t_ext <= ACC_W'(LOW_SEG_MAX_TEMP), chan == '0));
        num_s = cf.base - (t_ext <<< SCALE_SH);
        num_u = (num_s > 0) ? $unsigned(num_s) : '0;
    end

    tsc_div #(.NUM_W(ACC_W), .DEN_W(MUL_W), .Q_W(CODE_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (req),
        .num   (num_u),
        .den   (cf.mul),
        .busy  (busy),
        .done  (done),
        .quo   (code)
    );

    assign ready = !busy;
endmodule

// File: rtl/tsense_conv.sv
module tsense_conv
    import tsc_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TEMP_W = 12,
    parameter int OUT_W  = 16,
    parameter int UK_W   = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fwd_valid,
    output logic                     fwd_ready,
    input  logic [CH_W-1:0]          fwd_chan,
    input  logic [CODE_W-1:0]        fwd_code,
    output logic                     fwd_done,
    output logic signed [OUT_W-1:0]  fwd_temp,
    output logic [UK_W-1:0]          fwd_ukelvin,
    input  logic                     rev_valid,
    output logic                     rev_ready,
    input  logic [CH_W-1:0]          rev_chan,
    input  logic signed [TEMP_W-1:0] rev_temp,
    output logic                     rev_done,
    output logic [CODE_W-1:0]        rev_code
);
    assign fwd_ready = 1'b1;

    tsc_fwd #(.CH_W(CH_W), .OUT_W(OUT_W), .UK_W(UK_W)) u_fwd (
        .clk     (clk),
        .rst     (rst),
        .take    (fwd_valid),
        .chan    (fwd_chan),
        .code    (fwd_code),
        .done    (fwd_done),
        .temp    (fwd_temp),
        .ukelvin (fwd_ukelvin)
    );

    tsc_rev #(.CH_W(CH_W), .TEMP_W(TEMP_W)) u_rev (
        .clk   (clk),
        .rst   (rst),
        .req   (rev_valid),
        .chan  (rev_chan),
        .temp  (rev_temp),
        .ready (rev_ready),
        .done  (rev_done),
        .code  (rev_code)
    );
endmodule

// File: rtl/tsense_conv_chk.sv
module tsense_conv_chk #(
    parameter int LAT   = 40,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fwd_valid,
    input logic             fwd_ready,
    input logic             fwd_done,
    input logic [OUT_W-1:0] fwd_temp,
    input logic             rev_valid,
    input logic             rev_ready,
    input logic             rev_done,
    input logic [11:0]      rev_code
);
    logic [15:0] since_acc;

    always_ff @(posedge clk) begin
        if (rst)                        since_acc <= '0;
        else if (rev_valid && rev_ready) since_acc <= 16'd1;
        else if (!rev_ready)            since_acc <= since_acc + 16'd1;
    end

    p_fwd_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && fwd_ready) |=> fwd_done);
    p_fwd_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !(fwd_valid && fwd_ready) |=> !fwd_done);
    p_fwd_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(fwd_temp) |-> fwd_done);
    p_rev_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (rev_valid && rev_ready) |=> !rev_ready);
    p_rev_done_ready_r8: assert property (@(posedge clk) disable iff (rst)
        rev_done |-> rev_ready);
    p_rev_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rev_done |=> !rev_done);
    p_rev_latency_r8: assert property (@(posedge clk) disable iff (rst)
        rev_done |-> (since_acc == 16'(LAT + 1)));
    p_rev_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rev_code) |-> rev_done);
endmodule

bind tsense_conv tsense_conv_chk #(.LAT(tsc_pkg::ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_done  (fwd_done),
    .fwd_temp  (fwd_temp),
    .rev_valid (rev_valid),
    .rev_ready (rev_ready),
    .rev_done  (rev_done),
    .rev_code  (rev_code)
);

// File: tb/test_tsense_conv.sv
`timescale 1ns/1ps
module test_tsense_conv;
    localparam int LAT = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwd_valid = 1'b0, rev_valid = 1'b0;
    logic fwd_chan = 1'b0, rev_chan = 1'b0;
    logic [11:0] fwd_code = '0;
    logic signed [11:0] rev_temp = '0;
    logic fwd_ready, fwd_done, rev_ready, rev_done;
    logic signed [15:0] fwd_temp;
    logic [31:0] fwd_ukelvin;
    logic [11:0] rev_code;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tsense_conv i_tsense_conv (
        .clk(clk), .rst(rst),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_chan(fwd_chan),
        .fwd_code(fwd_code), .fwd_done(fwd_done), .fwd_temp(fwd_temp),
        .fwd_ukelvin(fwd_ukelvin),
        .rev_valid(rev_valid), .rev_ready(rev_ready), .rev_chan(rev_chan),
        .rev_temp(rev_temp), .rev_done(rev_done), .rev_code(rev_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_temp(input int ch, input int code);
        longint base, mul;
        if (code >= 'h500) begin base = 233832448; mul = 124885; end
        else if (ch == 0)  begin base = 271581184; mul = 152253; end
        else               begin base = 289406976; mul = 166723; end
        return (base - longint'(code) * mul) >>> 20;
    endfunction

    function automatic string fwd_tag(input int ch, input int code);
        if (code >= 'h500) return "R1";
        else if (ch == 0)  return "R2";
        else               return "R3";
    endfunction

    function automatic longint exp_code(input int ch, input int t, output string tag);
        longint base, mul, num, q;
        if (t <= 70)      begin base = 233832448; mul = 124885; tag = "R5"; end
        else if (ch == 0) begin base = 271581184; mul = 152253; tag = "R6"; end
        else              begin base = 289406976; mul = 166723; tag = "R6"; end
        num = base - longint'(t) * 1048576;
        if (num <= 0) begin tag = "R7"; return 0; end
        q = num / mul;
        if (q > 4095) begin tag = "R7"; return 4095; end
        return q;
    endfunction

    task automatic check_fwd(input int ch, input int code);
        longint et = exp_temp(ch, code);
        string tg = fwd_tag(ch, code);
        check(fwd_done == 1'b1, tg, "fwd_done", longint'(fwd_done), 1);
        check(longint'(fwd_temp) == et, tg, "fwd_temp", longint'(fwd_temp), et);
        check(longint'(fwd_ukelvin) == et * 1000000 + 273150000, "R4", "fwd_ukelvin",
              longint'(fwd_ukelvin), et * 1000000 + 273150000);
    endtask

    task automatic do_fwd(input int ch, input int code);
        @(negedge clk);
        fwd_valid = 1'b1; fwd_chan = ch[0]; fwd_code = code[11:0];
        @(negedge clk);
        fwd_valid = 1'b0;
        check_fwd(ch, code);
        @(negedge clk);
        check(fwd_done == 1'b0, "R1", "fwd_done pulse end", longint'(fwd_done), 0);
    endtask

    task automatic do_rev(input int ch, input int t, input bit with_fwd, input bit spam);
        string tg;
        longint ec = exp_code(ch, t, tg);
        int k = 0;
        int fc = 0;
        int fcode = 0;
        while (!rev_ready) @(negedge clk);
        rev_valid = 1'b1; rev_chan = ch[0]; rev_temp = t[11:0];
        if (with_fwd) begin
            fc = int'($urandom % 2); fcode = int'($urandom % 4096);
            fwd_valid = 1'b1; fwd_chan = fc[0]; fwd_code = fcode[11:0];
        end
        @(negedge clk);
        rev_valid = 1'b0; fwd_valid = 1'b0;
        check(rev_ready == 1'b0, "R8", "rev_ready after take", longint'(rev_ready), 0);
        if (with_fwd) check_fwd(fc, fcode); // R9 same-cycle take
        while (!rev_done && k < 200) begin
            if (spam && k == 2) begin rev_valid = 1'b1; rev_temp = 12'sd2047 - t[11:0]; rev_chan = ~ch[0]; end
            if (spam && k == 3) rev_valid = 1'b0;
            if (with_fwd && k == 5) begin
                fc = int'($urandom % 2); fcode = int'($urandom % 4096);
                fwd_valid = 1'b1; fwd_chan = fc[0]; fwd_code = fcode[11:0];
            end
            if (with_fwd && k == 6) begin
                fwd_valid = 1'b0;
                check(fwd_done == 1'b1, "R9", "fwd_done during divide", longint'(fwd_done), 1);
                check(longint'(fwd_temp) == exp_temp(fc, fcode), "R9", "fwd_temp during divide",
                      longint'(fwd_temp), exp_temp(fc, fcode));
            end
            @(negedge clk);
            k++;
        end
        check(k == LAT, "R8", "reverse latency", k, LAT);
        check(longint'(rev_code) == ec, tg, "rev_code", longint'(rev_code), ec);
        @(negedge clk);
        check(rev_done == 1'b0, "R8", "rev_done single pulse", longint'(rev_done), 0);
        check(longint'(rev_code) == ec, "R8", "rev_code held", longint'(rev_code), ec);
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(fwd_done == 1'b0 && rev_done == 1'b0, "R10", "done in reset", longint'({fwd_done, rev_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(rev_ready == 1'b1 && fwd_ready == 1'b1, "R10", "ready after reset", longint'({fwd_ready, rev_ready}), 3);
        check(fwd_temp == '0 && fwd_ukelvin == '0 && rev_code == '0, "R10", "outputs zero",
              longint'(fwd_temp) + longint'(rev_code), 0);

        // forward corner cases
        do_fwd(0, 'h500); do_fwd(1, 'h500); do_fwd(0, 'h4FF); do_fwd(1, 'h4FF);
        do_fwd(0, 0); do_fwd(1, 0); do_fwd(1, 'hFFF); do_fwd(0, 'h7A3);
        // reverse corner cases
        do_rev(0, 70, 0, 0); do_rev(1, 70, 0, 0);
        do_rev(0, 71, 0, 0); do_rev(1, 71, 0, 0);
        do_rev(0, -2048, 0, 0); do_rev(1, 2047, 0, 0); do_rev(0, 300, 0, 0);
        do_rev(1, 105, 1, 1); do_rev(0, 90, 1, 1); do_rev(1, -40, 1, 0);
        // random mix
        for (int i = 0; i < 40; i++) do_fwd(int'($urandom % 2), int'($urandom % 4096));
        for (int i = 0; i < 20; i++)
            do_rev(int'($urandom % 2), int'($urandom % 351) - 100, ($urandom % 2) == 1, ($urandom % 2) == 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule